// File: doc/BRIEF.md
# Upward-Growing Stack Pointer with Bound Checking

This block keeps the pointer of a software stack that lives in byte-addressed data RAM and holds 16-bit words. A push writes the word at the slot the pointer names and then advances the pointer by one word (two bytes). A pop steps the pointer back by one word first and then reads the slot it now names. The pointer therefore always names the first free word, and the stack grows toward higher addresses. The block drives the RAM address, the write enable, the write data and the read enable in the cycle of the request. The RAM, and whatever reaction follows an error, sit outside the block.

Every push is compared against a limit register that software can write. Every pop is compared against a fixed base address, which is also the value the pointer takes at reset. An access that would leave the stack is dropped and leaves the pointer where it was. It also raises a sticky error flag, which software clears with a one-cycle strobe. Software can also load the pointer directly, as it would an ordinary register. The pointer stays even at all times.

Top module: `sw_stack_ptr`

## Requirements
- R1: After reset the pointer equals the BASE parameter, the limit equals the LIMIT_RST parameter, both error flags are 0, and no memory access is requested.
- R2: A push alone (push_req=1, pop_req=0, ptr_wr=0) with ptr <= limit drives mem_we=1, mem_addr=ptr and mem_wdata=push_data in the same cycle, and ptr increases by 2 at the next clock edge.
- R3: A pop alone with ptr > BASE drives mem_re=1 and mem_addr=ptr-2 in the same cycle, and ptr decreases by 2 at the next clock edge.
- R4: ptr_wr=1 loads ptr with ptr_wdata with bit 0 forced to 0. In the same cycle it cancels any push or pop request: there is no memory access and no error flag is set. The pointer is always even.
- R5: A push alone with ptr > limit does not write (mem_we=0), leaves ptr unchanged and sets ovf_err.
- R6: A pop alone with ptr <= BASE does not read (mem_re=0), leaves ptr unchanged and sets unf_err.
- R7: Push and pop requested together without ptr_wr perform neither access, leave ptr unchanged and set both ovf_err and unf_err.
- R8: Each error flag stays set until err_clr=1. When a new error and err_clr arrive in the same cycle, the flag stays set.
- R9: lim_wr=1 loads the limit register with lim_wdata with bit 0 forced to 0. The limit port shows the value after the next edge, and the new limit governs pushes from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push one word |
| push_data | input | DW | Word to push |
| pop_req | input | 1 | Pop one word |
| ptr_wr | input | 1 | Direct pointer load |
| ptr_wdata | input | AW | Value for direct pointer load |
| lim_wr | input | 1 | Limit register load |
| lim_wdata | input | AW | Value for limit register load |
| err_clr | input | 1 | Clear both error flags |
| mem_addr | output | AW | RAM byte address for the current access |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DW | RAM write data |
| mem_re | output | 1 | RAM read enable |
| ptr | output | AW | Current stack pointer |
| limit | output | AW | Current upper limit |
| ovf_err | output | 1 | Sticky overflow flag |
| unf_err | output | 1 | Sticky underflow flag |

## Verification
If the pointer register is wrong, the fault shows on mem_addr at the very next push or pop. It also shows on the ptr port one edge after the faulty update. A bound compare that is off by one word is the subtle case. It appears only on the access at the exact boundary, as one write or read that should not happen (or one that is missing), together with a missing or spurious flag one edge later. For that reason the sweeps fill and drain the stack to the precise boundary, for every limit value in a small range. A flag that is not sticky, or that is cleared wrongly, shows up on the idle and clear cycles that follow an error.

// File: rtl/sw_stack_ptr.sv
module sw_stack_ptr #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] BASE = 'h0800,
  parameter logic [AW-1:0] LIMIT_RST = 'h0FFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          lim_wr,
  input  logic [AW-1:0] lim_wdata,
  input  logic          err_clr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] limit,
  output logic          ovf_err,
  output logic          unf_err
);
  localparam logic [AW-1:0] STEP = AW'(2);
  localparam logic [AW-1:0] EVEN = ~AW'(1);

  logic push_only, pop_only, clash, ovf_hit, unf_hit;

  assign clash     = push_req & pop_req & ~ptr_wr;
  assign push_only = push_req & ~pop_req & ~ptr_wr;
  assign pop_only  = pop_req & ~push_req & ~ptr_wr;
  assign ovf_hit   = push_only & (ptr > limit);
  assign unf_hit   = pop_only & (ptr <= BASE);

  assign mem_we    = push_only & ~ovf_hit;
  assign mem_re    = pop_only & ~unf_hit;
  assign mem_addr  = push_req ? ptr : ptr - STEP;
  assign mem_wdata = push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= BASE & EVEN;
    end else if (ptr_wr) begin
      ptr <= ptr_wdata & EVEN;
    end else if (mem_we) begin
      ptr <= ptr + STEP;
    end else if (mem_re) begin
      ptr <= ptr - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit <= LIMIT_RST & EVEN;
    else if (lim_wr) limit <= lim_wdata & EVEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_err <= 1'b0;
      unf_err <= 1'b0;
    end else begin
      ovf_err <= ovf_hit | clash | (ovf_err & ~err_clr);
      unf_err <= unf_hit | clash | (unf_err & ~err_clr);
    end
  end
endmodule

// File: rtl/stack_ptr_chk.sv
module stack_ptr_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 'h0800
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          pop_req,
  input logic          ptr_wr,
  input logic          err_clr,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] ptr,
  input logic [AW-1:0] limit,
  input logic          ovf_err,
  input logic          unf_err
);
  a_r2_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr == ptr && push_req && !pop_req && !ptr_wr));
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ptr == $past(ptr) + AW'(2));
  a_r3_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr == ptr - AW'(2) && pop_req && !push_req && !ptr_wr));
  a_r3_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ptr == $past(ptr) - AW'(2));
  a_r4_wr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |-> (!mem_we && !mem_re));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !ptr_wr && ptr > limit) |=> (ovf_err && ptr == $past(ptr)));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !ptr_wr && ptr <= BASE) |=> (unf_err && ptr == $past(ptr)));
  a_r7_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !ptr_wr) |-> (!mem_we && !mem_re));
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !err_clr) |=> ovf_err);
  a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_err && !err_clr) |=> unf_err);

  always @(posedge clk) begin
    if (rst_n) begin
      a_r4_even: assert (ptr[0] == 1'b0 && limit[0] == 1'b0);
    end
  end
endmodule

bind sw_stack_ptr stack_ptr_chk #(.AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
  .ptr_wr(ptr_wr), .err_clr(err_clr), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_re(mem_re), .ptr(ptr), .limit(limit), .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/sim_sw_stack_ptr.sv
module sim_sw_stack_ptr;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] BASE = 8'h10;
  localparam logic [AW-1:0] LRST = 8'h1E;

  logic clk = 0, rst_n = 0;
  logic push_req = 0, pop_req = 0, ptr_wr = 0, lim_wr = 0, err_clr = 0;
  logic [DW-1:0] push_data = '0;
  logic [AW-1:0] ptr_wdata = '0, lim_wdata = '0;
  logic [AW-1:0] mem_addr, ptr, limit;
  logic [DW-1:0] mem_wdata;
  logic mem_we, mem_re, ovf_err, unf_err;

  int total = 0, bad = 0;
  logic [AW-1:0] m_ptr, m_lim;
  logic m_ovf, m_unf;

  always #4 clk = ~clk;

  sw_stack_ptr #(.AW(AW), .DW(DW), .BASE(BASE), .LIMIT_RST(LRST)) u0 (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
    .pop_req(pop_req), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .lim_wr(lim_wr),
    .lim_wdata(lim_wdata), .err_clr(err_clr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .ptr(ptr), .limit(limit),
    .ovf_err(ovf_err), .unf_err(unf_err));

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit pu, bit po, logic [DW-1:0] d, bit pw, logic [AW-1:0] pwd,
                     bit lw, logic [AW-1:0] lwd, bit clr);
    string tag;
    bit we, re, eo, eu;
    logic [AW-1:0] np;
    @(negedge clk);
    push_req = pu; pop_req = po; push_data = d; ptr_wr = pw; ptr_wdata = pwd;
    lim_wr = lw; lim_wdata = lwd; err_clr = clr;
    we = !pw && pu && !po && (m_ptr <= m_lim);
    re = !pw && po && !pu && (m_ptr > BASE);
    eo = !pw && pu && (po || m_ptr > m_lim);
    eu = !pw && po && (pu || m_ptr <= BASE);
    np = pw ? (pwd & 8'hFE) : we ? m_ptr + 8'd2 : re ? m_ptr - 8'd2 : m_ptr;
    if (pw) tag = "R4";
    else if (pu && po) tag = "R7";
    else if (pu) tag = eo ? "R5" : "R2";
    else if (po) tag = eu ? "R6" : "R3";
    else if (lw) tag = "R9";
    else tag = "R8";
    #1;
    chk(tag, "mem_we", int'(mem_we), int'(we));
    chk(tag, "mem_re", int'(mem_re), int'(re));
    if (we) begin
      chk(tag, "mem_addr", int'(mem_addr), int'(m_ptr));
      chk(tag, "mem_wdata", int'(mem_wdata), int'(d));
    end
    if (re) chk(tag, "mem_addr", int'(mem_addr), int'(m_ptr - 8'd2));
    m_ptr = np;
    if (lw) m_lim = lwd & 8'hFE;
    m_ovf = eo | (m_ovf & !clr);
    m_unf = eu | (m_unf & !clr);
    @(posedge clk); #1;
    chk(tag, "ptr", int'(ptr), int'(m_ptr));
    chk(tag, "limit", int'(limit), int'(m_lim));
    chk(tag, "ovf_err", int'(ovf_err), int'(m_ovf));
    chk(tag, "unf_err", int'(unf_err), int'(m_unf));
    @(negedge clk);
    push_req = 0; pop_req = 0; ptr_wr = 0; lim_wr = 0; err_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_ptr = BASE; m_lim = LRST; m_ovf = 0; m_unf = 0;
    #20; rst_n = 1; #5;
    chk("R1", "ptr", int'(ptr), int'(BASE));
    chk("R1", "limit", int'(limit), int'(LRST));
    chk("R1", "ovf_err", int'(ovf_err), 0);
    chk("R1", "unf_err", int'(unf_err), 0);
    chk("R1", "mem_we", int'(mem_we), 0);
    chk("R1", "mem_re", int'(mem_re), 0);
    // R2 fill to the limit, R5 on the extra push
    for (int i = 0; i < 10; i++) cyc(1, 0, 16'hA500 + 16'(i), 0, 0, 0, 0, 0);
    // R8 sticky over idle cycles, set-and-clear together, then clear
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 16'h1234, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    // R3 drain, R6 on the extra pops
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    // R7 simultaneous push and pop
    cyc(1, 0, 16'h0001, 0, 0, 0, 0, 0);
    cyc(1, 1, 16'h0002, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    // R4 direct load with odd value, and load overriding push and pop
    cyc(0, 0, 0, 1, 8'h2B, 0, 0, 0);
    cyc(1, 0, 16'h0BAD, 1, 8'h15, 0, 0, 0);
    cyc(0, 1, 0, 1, 8'h1A, 0, 0, 0);
    cyc(1, 1, 0, 1, 8'h12, 0, 0, 0);
    // R9 limit sweep: odd writes, then fill to each boundary
    for (int l = 16; l <= 32; l += 2) begin
      cyc(0, 0, 0, 1, BASE, 1, 8'(l + 1), 1);
      for (int k = 0; k < 11; k++) cyc(1, 0, 16'(l * 16 + k), 0, 0, 0, 0, 0);
      for (int k = 0; k < 11; k++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule